// File: doc/BRIEF.md
# SDRAM Bank Command Checker

This block listens to the command pins of a single-data-rate SDRAM and follows every bank through its life cycle. A bank can be idle, opening a row, holding an open row, bursting a read or a write, precharging, or running a read or write that closes the row by itself. Each clock it decodes the chip-select, row-strobe, column-strobe and write-enable lines. It uses the bank address to find the bank or banks a command reaches and moves them to their next state. When a command is not allowed in the state of a bank it reaches, the block reports a violation with a reason code and the bank number, one clock later.

The row-to-column delay, the precharge time and the burst length are configuration inputs given in clock cycles. Bursts that nothing interrupts finish on their own and return the bank to the open-row state. A command that is flagged is dropped, so the tracked bank state matches what the memory itself would do. The block sits beside a memory controller or on a bus monitor in a test environment. It drives nothing onto the memory bus.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Commands decode from {ras_n, cas_n, we_n} when cs_n is low: 111 no-op, 011 ACTIVE, 101 READ, 100 WRITE, 110 BURST TERMINATE, 010 PRECHARGE, 001 AUTO REFRESH, 000 LOAD MODE. With cs_n high the cycle is a no-op, whatever the other pins carry.
- R2: A command is checked and acted on only when cke is high in the current cycle and was high in the previous one. In any other cycle no violation is raised and no bank state changes because of the command.
- R3: Bank states on bank_state (3 bits per bank, bank i at bits 3i+2:3i) are 0 idle, 1 opening, 2 open, 3 read, 4 write, 5 precharging, 6 read with auto close, 7 write with auto close. ACTIVE to an idle bank gives state 1 for cfg_trcd cycles, then state 2.
- R4: In an idle bank, READ, WRITE, BURST TERMINATE and ACTIVE-free illegal commands raise code 2. PRECHARGE is legal there and leaves the bank idle.
- R5: In an open bank, READ or WRITE with a10 low enters state 3 or 4 for cfg_bl cycles, then returns to state 2. ACTIVE and BURST TERMINATE there raise code 2.
- R6: During a read or write burst, a new READ or WRITE restarts a full burst, BURST TERMINATE returns the bank to state 2 at once, and PRECHARGE cuts the burst short and starts precharging.
- R7: PRECHARGE gives state 5 for cfg_trp cycles, then idle. With a10 high it reaches every bank.
- R8: READ or WRITE with a10 high enters state 6 or 7 for cfg_bl + cfg_trp cycles, then idle.
- R9: A bank in state 1, 5, 6 or 7 raises code 1 for any command that reaches it other than a no-op. Legal commands to other banks are still accepted.
- R10: AUTO REFRESH and LOAD MODE reach all banks. They are legal only when every bank is idle. Otherwise each bank in state 2, 3 or 4 raises code 3.
- R11: viol, viol_code (1 busy, 2 illegal in state, 3 not all idle) and viol_bank are registered. They show the result of a command in the cycle after the edge that samples it. When several banks raise codes, the lowest bank number is reported. A flagged command leaves that bank's state unchanged.
- R12: Synchronous reset puts every bank in idle and clears the violation outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Memory clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-close flag on READ/WRITE, all-bank flag on PRECHARGE |
| cfg_trcd | input | CNT_W | Row-to-column delay in cycles |
| cfg_trp | input | CNT_W | Precharge time in cycles |
| cfg_bl | input | CNT_W | Burst length in cycles |
| viol | output | 1 | Violation seen on the previous command |
| viol_code | output | 2 | Reason code of the reported violation |
| viol_bank | output | BA_W | Lowest bank that raised the violation |
| bank_state | output | 3*2^BA_W | Packed per-bank state |

## Verification
A command table walks banks through each legal path: opening, bursts that run out, bursts cut short by terminate or precharge, a restarted burst, and both auto-close forms. Each is followed by no-ops timed to land just before and just after each countdown ends, so an off-by-one in any timer shows as a wrong state code. Illegal commands are placed in every state class: a busy bank, an idle bank, an open bank, and refresh or mode load while a bank is open. This separates codes 1, 2 and 3 and confirms the dropped command leaves the state alone. All-bank precharge onto two precharging banks checks the lowest-bank rule. Directed runs cover clock-enable gating, a longer row delay, inhibited commands that would otherwise be illegal, and reset in the middle of an operation.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE    = 3'd0,
    BS_OPENING = 3'd1,
    BS_OPEN    = 3'd2,
    BS_READ    = 3'd3,
    BS_WRITE   = 3'd4,
    BS_PRECH   = 3'd5,
    BS_RDAP    = 3'd6,
    BS_WRAP    = 3'd7
  } bstate_e;

  typedef enum logic [1:0] {
    VC_NONE    = 2'd0,
    VC_BUSY    = 2'd1,
    VC_ILLEGAL = 2'd2,
    VC_NOTIDLE = 2'd3
  } vcode_e;

endpackage

// File: rtl/sdcg_decode.sv
module sdcg_decode
  import sdcg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic chk_en,
  output cmd_e cmd
);

  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b0;
    else     cke_q <= cke;
  end

  assign chk_en = cke & cke_q;

  always_comb begin
    if (chk_en && !cs_n) cmd = cmd_e'({ras_n, cas_n, we_n});
    else                 cmd = CMD_NOP;
  end

endmodule

// File: rtl/sdcg_bank.sv
module sdcg_bank
  import sdcg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic             hit,
  input  logic             a10,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [CNT_W-1:0] cfg_bl,
  output bstate_e          state,
  output vcode_e           vcode
);

  localparam int TW = CNT_W + 1;

  logic [TW-1:0] cnt, go_cnt;
  logic [TW-1:0] len_rcd, len_rp, len_bl, len_ap;
  logic          go, timed;
  bstate_e       go_state, done_state;

  assign len_rcd = {1'b0, cfg_trcd};
  assign len_rp  = {1'b0, cfg_trp};
  assign len_bl  = {1'b0, cfg_bl};
  assign len_ap  = len_bl + len_rp;

  // Where a timed state lands once its countdown runs out.
  always_comb begin
    timed      = 1'b1;
    done_state = BS_IDLE;
    unique case (state)
      BS_IDLE, BS_OPEN:    timed = 1'b0;
      BS_OPENING:          done_state = BS_OPEN;
      BS_READ, BS_WRITE:   done_state = BS_OPEN;
      default:             done_state = BS_IDLE;
    endcase
  end

  // Legality and command effect for this bank.
  always_comb begin
    vcode    = VC_NONE;
    go       = 1'b0;
    go_state = state;
    go_cnt   = '0;
    if (hit && cmd != CMD_NOP) begin
      unique case (state)
        BS_IDLE: begin
          unique case (cmd)
            CMD_ACT: begin go = 1'b1; go_state = BS_OPENING; go_cnt = len_rcd; end
            CMD_PRE, CMD_REF, CMD_LMR: ;
            default: vcode = VC_ILLEGAL;
          endcase
        end
        BS_OPEN, BS_READ, BS_WRITE: begin
          unique case (cmd)
            CMD_RD: begin
              go       = 1'b1;
              go_state = a10 ? BS_RDAP : BS_READ;
              go_cnt   = a10 ? len_ap : len_bl;
            end
            CMD_WR: begin
              go       = 1'b1;
              go_state = a10 ? BS_WRAP : BS_WRITE;
              go_cnt   = a10 ? len_ap : len_bl;
            end
            CMD_PRE: begin go = 1'b1; go_state = BS_PRECH; go_cnt = len_rp; end
            CMD_BST: begin
              if (state == BS_OPEN) vcode = VC_ILLEGAL;
              else begin go = 1'b1; go_state = BS_OPEN; end
            end
            CMD_REF, CMD_LMR: vcode = VC_NOTIDLE;
            default: vcode = VC_ILLEGAL;
          endcase
        end
        default: vcode = VC_BUSY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BS_IDLE;
      cnt   <= '0;
    end else if (go) begin
      state <= go_state;
      cnt   <= go_cnt;
    end else if (timed) begin
      if (cnt <= TW'(1)) begin
        state <= done_state;
        cnt   <= '0;
      end else begin
        cnt <= cnt - TW'(1);
      end
    end
  end

  // R4: an idle bank leaves idle only through ACTIVE
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == BS_IDLE && !(hit && cmd == CMD_ACT)) |=> state == BS_IDLE);

  // R3: opening can only continue or become open
  p_opening_path_r3: assert property (@(posedge clk) disable iff (rst)
    state == BS_OPENING |=> (state == BS_OPENING || state == BS_OPEN));

  // R8: auto-close states only persist or fall to idle
  p_ap_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (state == BS_RDAP || state == BS_WRAP) |=> (state == $past(state) || state == BS_IDLE));

  // R7: precharging only persists or falls to idle
  p_prech_exit_r7: assert property (@(posedge clk) disable iff (rst)
    state == BS_PRECH |=> (state == BS_PRECH || state == BS_IDLE));

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdcg_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int CNT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  input  logic [CNT_W-1:0]          cfg_trcd,
  input  logic [CNT_W-1:0]          cfg_trp,
  input  logic [CNT_W-1:0]          cfg_bl,
  output logic                      viol,
  output logic [1:0]                viol_code,
  output logic [BA_W-1:0]           viol_bank,
  output logic [3*(1<<BA_W)-1:0]    bank_state
);

  localparam int NB = 1 << BA_W;

  cmd_e           cmd;
  logic           chk_en;
  logic [NB-1:0]  hit;
  logic [NB-1:0]  busy_hit;
  bstate_e        bstate [NB];
  vcode_e         vcode  [NB];
  vcode_e         sel_code;
  logic [BA_W-1:0] sel_bank;

  sdcg_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .chk_en (chk_en),
    .cmd    (cmd)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign hit[i] = (cmd == CMD_REF) || (cmd == CMD_LMR) ||
                    (cmd == CMD_PRE && a10) || (ba == BA_W'(i));

    sdcg_bank #(.CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .cmd      (cmd),
      .hit      (hit[i]),
      .a10      (a10),
      .cfg_trcd (cfg_trcd),
      .cfg_trp  (cfg_trp),
      .cfg_bl   (cfg_bl),
      .state    (bstate[i]),
      .vcode    (vcode[i])
    );

    assign bank_state[3*i +: 3] = bstate[i];
    assign busy_hit[i] = hit[i] && cmd != CMD_NOP &&
                         (bstate[i] == BS_OPENING || bstate[i] == BS_PRECH ||
                          bstate[i] == BS_RDAP    || bstate[i] == BS_WRAP);
  end

  // Lowest flagged bank wins.
  always_comb begin
    sel_code = VC_NONE;
    sel_bank = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (vcode[i] != VC_NONE) begin
        sel_code = vcode[i];
        sel_bank = BA_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= 2'd0;
      viol_bank <= '0;
    end else begin
      viol      <= (sel_code != VC_NONE);
      viol_code <= sel_code;
      viol_bank <= sel_bank;
    end
  end

  // R9: a busy bank reached by a real command is always reported
  p_busy_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (|busy_hit) |=> (viol && viol_code != 2'd0));

  // R2: no report for a cycle that clock-enable gating skips
  p_skip_r2: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> !viol);

endmodule

// File: tb/tb_sdram_cmd_guard.sv
module tb_sdram_cmd_guard;
  localparam int BA_W = 2;
  localparam int CW   = 4;

  localparam logic [2:0] C_LMR = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
  localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;
  localparam logic [2:0] SI = 3'd0, SG = 3'd1, SA = 3'd2, SR = 3'd3;
  localparam logic [2:0] SW = 3'd4, SP = 3'd5, SRP = 3'd6, SWP = 3'd7;
  localparam logic [3:0] T1 = 4'd1, T2 = 4'd2, T3 = 4'd3, T4 = 4'd4, T5 = 4'd5, T6 = 4'd6;
  localparam logic [3:0] T7 = 4'd7, T8 = 4'd8, T9 = 4'd9, T10 = 4'd10, T11 = 4'd11, T12 = 4'd12;

  typedef struct packed {
    logic        cs;
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic        a10;
    logic        ev;
    logic [1:0]  code;
    logic [1:0]  vb;
    logic [3:0]  tag;
    logic [11:0] st;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t TBL [NV] = '{
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T12, SI, SI, SI, SI },
    {1'b0, C_ACT, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SI, SI, SG },
    {1'b0, C_RD,  2'd0, 1'b0, 1'b1, 2'd1, 2'd0, T9,  SI, SI, SI, SG },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SI, SI, SA },
    {1'b0, C_RD,  2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T5,  SI, SI, SI, SR },
    {1'b0, C_BST, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T6,  SI, SI, SI, SA },
    {1'b0, C_WR,  2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T5,  SI, SI, SI, SW },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T5,  SI, SI, SI, SW },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T5,  SI, SI, SI, SA },
    {1'b0, C_RD,  2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T6,  SI, SI, SI, SR },
    {1'b0, C_RD,  2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T6,  SI, SI, SI, SR },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T6,  SI, SI, SI, SR },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T6,  SI, SI, SI, SA },
    {1'b0, C_ACT, 2'd0, 1'b0, 1'b1, 2'd2, 2'd0, T5,  SI, SI, SI, SA },
    {1'b0, C_BST, 2'd0, 1'b0, 1'b1, 2'd2, 2'd0, T5,  SI, SI, SI, SA },
    {1'b0, C_RD,  2'd1, 1'b0, 1'b1, 2'd2, 2'd1, T4,  SI, SI, SI, SA },
    {1'b0, C_PRE, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, T4,  SI, SI, SI, SA },
    {1'b0, C_REF, 2'd2, 1'b0, 1'b1, 2'd3, 2'd0, T10, SI, SI, SI, SA },
    {1'b0, C_RD,  2'd0, 1'b1, 1'b0, 2'd0, 2'd0, T8,  SI, SI, SI, SRP},
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T8,  SI, SI, SI, SRP},
    {1'b0, C_WR,  2'd0, 1'b0, 1'b1, 2'd1, 2'd0, T9,  SI, SI, SI, SRP},
    {1'b0, C_ACT, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, T9,  SI, SI, SG, SRP},
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T8,  SI, SI, SG, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SI, SA, SI },
    {1'b0, C_WR,  2'd1, 1'b0, 1'b0, 2'd0, 2'd0, T5,  SI, SI, SW, SI },
    {1'b0, C_PRE, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, T6,  SI, SI, SP, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T7,  SI, SI, SP, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T7,  SI, SI, SI, SI },
    {1'b0, C_LMR, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T10, SI, SI, SI, SI },
    {1'b0, C_ACT, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SG, SI, SI },
    {1'b0, C_ACT, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SG, SG, SI, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SG, SA, SI, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SA, SA, SI, SI },
    {1'b0, C_PRE, 2'd0, 1'b1, 1'b0, 2'd0, 2'd0, T7,  SP, SP, SI, SI },
    {1'b0, C_PRE, 2'd0, 1'b1, 1'b1, 2'd1, 2'd2, T11, SP, SP, SI, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T7,  SI, SI, SI, SI },
    {1'b0, C_ACT, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SI, SG, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SI, SG, SI },
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T3,  SI, SI, SA, SI },
    {1'b0, C_WR,  2'd1, 1'b1, 1'b0, 2'd0, 2'd0, T8,  SI, SI, SWP, SI},
    {1'b0, C_ACT, 2'd1, 1'b0, 1'b1, 2'd1, 2'd1, T9,  SI, SI, SWP, SI},
    {1'b0, C_RD,  2'd1, 1'b0, 1'b1, 2'd1, 2'd1, T9,  SI, SI, SWP, SI},
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T8,  SI, SI, SWP, SI},
    {1'b0, C_NOP, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T8,  SI, SI, SI, SI },
    {1'b1, C_ACT, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, T1,  SI, SI, SI, SI },
    {1'b1, C_RD,  2'd2, 1'b0, 1'b0, 2'd0, 2'd0, T1,  SI, SI, SI, SI },
    {1'b0, C_BST, 2'd3, 1'b0, 1'b1, 2'd2, 2'd3, T1,  SI, SI, SI, SI }
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [BA_W-1:0] ba;
  logic [CW-1:0] cfg_trcd, cfg_trp, cfg_bl;
  logic viol;
  logic [1:0] viol_code;
  logic [BA_W-1:0] viol_bank;
  logic [11:0] bank_state;

  sdram_cmd_guard #(.BA_W(BA_W), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_bl(cfg_bl), .viol(viol), .viol_code(viol_code), .viol_bank(viol_bank),
    .bank_state(bank_state)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic string rq(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic drive(input logic cs, input logic [2:0] c, input logic [1:0] b,
                       input logic a);
    cs_n = cs;
    {ras_n, cas_n, we_n} = c;
    ba = b;
    a10 = a;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
    ba = '0; a10 = 1'b0;
    cfg_trcd = 4'd2; cfg_trp = 4'd2; cfg_bl = 4'd2;
    repeat (3) @(negedge clk);
    check("R12", "reset viol", {31'd0, viol}, 32'd0);
    check("R12", "reset states", {20'd0, bank_state}, 32'd0);
    rst = 1'b0;

    // Table walk: R1 through R11 paths
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].cs, TBL[i].cmd, TBL[i].ba, TBL[i].a10);
      check(rq(TBL[i].tag), $sformatf("vec %0d viol", i), {31'd0, viol}, {31'd0, TBL[i].ev});
      if (TBL[i].ev) begin
        check(rq(TBL[i].tag), $sformatf("vec %0d code", i), {30'd0, viol_code}, {30'd0, TBL[i].code});
        check(rq(TBL[i].tag), $sformatf("vec %0d bank", i), {30'd0, viol_bank}, {30'd0, TBL[i].vb});
      end
      check(rq(TBL[i].tag), $sformatf("vec %0d states", i), {20'd0, bank_state}, {20'd0, TBL[i].st});
    end

    // R2: clock enable low, then first high cycle, both skipped
    cke = 1'b0;
    drive(1'b0, C_RD, 2'd0, 1'b0);
    check("R2", "cke low viol", {31'd0, viol}, 32'd0);
    check("R2", "cke low states", {20'd0, bank_state}, 32'd0);
    cke = 1'b1;
    drive(1'b0, C_ACT, 2'd0, 1'b0);
    check("R2", "cke rising viol", {31'd0, viol}, 32'd0);
    check("R2", "cke rising states", {20'd0, bank_state}, 32'd0);
    drive(1'b0, C_RD, 2'd0, 1'b0);
    check("R2", "cke steady viol", {31'd0, viol}, 32'd1);
    check("R2", "cke steady code", {30'd0, viol_code}, 32'd2);

    // R12: reset in the middle of an opening
    drive(1'b0, C_ACT, 2'd2, 1'b0);
    check("R12", "pre-reset state", {20'd0, bank_state}, {20'd0, SI, SG, SI, SI});
    rst = 1'b1;
    drive(1'b0, C_RD, 2'd2, 1'b0);
    check("R12", "mid reset states", {20'd0, bank_state}, 32'd0);
    check("R12", "mid reset viol", {31'd0, viol}, 32'd0);
    rst = 1'b0;

    // R3: longer row delay
    cfg_trcd = 4'd3;
    drive(1'b0, C_NOP, 2'd0, 1'b0);
    drive(1'b0, C_ACT, 2'd0, 1'b0);
    drive(1'b0, C_NOP, 2'd0, 1'b0);
    drive(1'b0, C_NOP, 2'd0, 1'b0);
    check("R3", "trcd=3 still opening", {20'd0, bank_state}, {20'd0, SI, SI, SI, SG});
    drive(1'b0, C_NOP, 2'd0, 1'b0);
    check("R3", "trcd=3 open", {20'd0, bank_state}, {20'd0, SI, SI, SI, SA});
    drive(1'b0, C_RD, 2'd0, 1'b0);
    check("R5", "read after trcd viol", {31'd0, viol}, 32'd0);

    summary();
    $finish;
  end
endmodule